// File: doc/BRIEF.md
# DMA Channel Termination Controller

This block holds the channel registers and the stop logic for a small multi-channel DMA engine. Each channel has a source pointer, a destination pointer, a remaining-transfer count and a control word. The control word has a run bit, an interrupt-enable bit and a completion flag. A shared mode word holds a global run bit, an NMI-halt flag and an address-fault flag. The block moves data with two bus cycles per transfer: it reads from the source pointer, then writes the read data to the destination pointer. Each bus cycle is a request that stays up until the slave acknowledges it.

A channel stops for one of three reasons, and each behaves differently. When its count runs out, it stops and raises its completion flag, which can drive an interrupt. When software clears its run bit, it stops silently. The third reason stops every channel at once, also without a completion flag: an NMI event, an address fault, or software clearing the global run bit. The stop takes effect at a bus-cycle boundary, and the pointers and count keep the result of the last transfer that finished.

Software restarts after a halt by clearing the halt flag and then setting a channel's run bit again. Channels are served in fixed priority order, and each grant covers one read/write pair.

Top module: `dma_term_ctrl`

## Requirements
- R1: When a write cycle completes with the channel count at 1, the count becomes 0, the channel's completion flag (control bit 2) is set, and the channel issues no further bus cycles.
- R2: irq[i] is high while channel i has both its completion flag and its interrupt-enable bit (control bit 1) set. It falls after software writes the control word with bit 2 equal to 0.
- R3: Clearing a channel's run bit (control bit 0) stops that channel at the end of the bus cycle in progress. Its completion flag stays 0, and its pointers and count keep the values of the last completed transfer.
- R4: A high cycle on nmi_evt sets the NMI flag (mode bit 1) and stops all channels at the end of the bus cycle in progress. No completion flag is set, and the registers hold the values of the last completed transfer.
- R5: While the NMI flag or the fault flag is set, or the global run bit is 0, no new bus cycle starts. After a halt flag is cleared, a channel whose run bit is 0 stays idle until software sets its run bit.
- R6: A read that returns bus_err still gets its write cycle. That transfer updates the pointers and count, the fault flag (mode bit 2) is set, and all channels then halt.
- R7: Writing 0 to the global run bit (mode bit 0) stops all channels at the end of the bus cycle in progress, without setting any completion flag.
- R8: Each completed write cycle adds STEP (4) to the channel's source and destination pointers and subtracts 1 from its count.
- R9: Among ready channels, the lowest-numbered one is granted. Each grant performs one read/write pair before arbitration runs again.
- R10: A transfer is a read (bus_wr=0) at the source pointer, then a write (bus_wr=1) of the returned data at the destination pointer. bus_req and bus_addr hold steady until bus_ack.
- R11: Register map: channel i occupies addresses 4*i to 4*i+3, holding source, destination, count and control in that order. The mode word is at address 4*NCH. Writing 1 to a flag bit (control bit 2, mode bits 1 and 2) has no effect. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register address |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational) |
| nmi_evt | input | 1 | NMI event pulse |
| bus_req | output | 1 | Bus cycle request |
| bus_wr | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | AW | Bus cycle address |
| bus_wdata | output | AW | Write data |
| bus_ack | input | 1 | Bus cycle acknowledge |
| bus_rdata | input | AW | Read data, valid with bus_ack |
| bus_err | input | 1 | Address error, valid with bus_ack |
| irq | output | NCH | Per-channel interrupt request |

## Verification
On every cycle, the assertions check the bus protocol: the request and address stay steady until acknowledged, every write directly follows an acknowledged read, and a faulted read is still followed by its write. They also check that no cycle starts while a halt condition holds, and that completion flags and interrupts rise only at a completed write. Only the bench scenarios can show the stop points: the exact counts and pointers left after each kind of stop, the flag-clear then run-bit restart order, and the grant order between channels. They are also the only way to show that writing 1 to a flag does nothing.

// File: rtl/dma_term_pkg.sv
// Shared types and field positions for the DMA termination controller.
// Assumes: the control and mode words use bits 0..2 as listed below.
package dma_term_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_READ  = 2'd1,
        SEQ_WRITE = 2'd2
    } seq_state_t;

    localparam int CTL_RUN  = 0;
    localparam int CTL_IEN  = 1;
    localparam int CTL_DONE = 2;

    localparam int MODE_RUN   = 0;
    localparam int MODE_NMI   = 1;
    localparam int MODE_FAULT = 2;

    localparam logic [1:0] FLD_SRC = 2'd0;
    localparam logic [1:0] FLD_DST = 2'd1;
    localparam logic [1:0] FLD_CNT = 2'd2;
    localparam logic [1:0] FLD_CTL = 2'd3;
endpackage

// File: rtl/dma_chan_regs.sv
// One channel's pointers, count and control bits.
// Assumes: a hardware update (completed write) takes priority over a
// software write to the same field in the same cycle.
module dma_chan_regs
    import dma_term_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 16,
    parameter int STEP  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_we,
    input  logic [1:0]       sw_fld,
    input  logic [AW-1:0]    sw_data,
    input  logic             hw_upd,
    output logic [AW-1:0]    src_q,
    output logic [AW-1:0]    dst_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             run_q,
    output logic             ien_q,
    output logic             done_q,
    output logic             ready
);
    localparam logic [AW-1:0]    STEP_V = AW'(STEP);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    // Pointer and count storage: hardware advance, else software load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
        end else if (hw_upd) begin
            src_q <= src_q + STEP_V;
            dst_q <= dst_q + STEP_V;
            cnt_q <= cnt_q - ONE;
        end else if (sw_we) begin
            case (sw_fld)
                FLD_SRC: src_q <= sw_data;
                FLD_DST: dst_q <= sw_data;
                FLD_CNT: cnt_q <= sw_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // Control bits: software writes run/ien, can only clear done; hardware sets done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            ien_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (sw_we && sw_fld == FLD_CTL) begin
                run_q <= sw_data[CTL_RUN];
                ien_q <= sw_data[CTL_IEN];
                if (!sw_data[CTL_DONE]) done_q <= 1'b0;
            end
            if (hw_upd && cnt_q == ONE) done_q <= 1'b1;
        end
    end

    // Channel wants service when enabled, not finished and count non-zero.
    always_comb begin
        ready = run_q && !done_q && (cnt_q != '0);
    end
endmodule

// File: rtl/dma_prio_arb.sv
// Fixed-priority pick: the lowest-numbered requesting channel wins.
// Assumes: purely combinational, evaluated only while the sequencer is idle.
module dma_prio_arb #(
    parameter int NCH = 4,
    parameter int IW  = 2
) (
    input  logic [NCH-1:0] req,
    output logic           any,
    output logic [IW-1:0]  idx
);
    // Scan from the highest channel down so the lowest request is kept last.
    always_comb begin
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/dma_xfer_seq.sv
// Read/write pair sequencer with bus-cycle-boundary halt handling.
// Assumes: a halt is examined only when a read completes. A write in flight
// always finishes and updates its channel. A faulted read proceeds to its write.
module dma_xfer_seq
    import dma_term_pkg::*;
#(
    parameter int AW = 32,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW-1:0] start_ch,
    input  logic [AW-1:0] src_cur,
    input  logic [AW-1:0] dst_cur,
    input  logic          run_cur,
    input  logic          halt_all,
    input  logic          bus_ack,
    input  logic [AW-1:0] bus_rdata,
    input  logic          bus_err,
    output logic          bus_req,
    output logic          bus_wr,
    output logic [AW-1:0] bus_addr,
    output logic [AW-1:0] bus_wdata,
    output logic [IW-1:0] cur_ch,
    output logic          upd,
    output logic          upd_fault
);
    seq_state_t    state;
    logic [AW-1:0] data_q;
    logic          err_pend;

    // State, granted channel, captured read data and pending fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            cur_ch   <= '0;
            data_q   <= '0;
            err_pend <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        cur_ch   <= start_ch;
                        err_pend <= 1'b0;
                        state    <= SEQ_READ;
                    end
                end
                SEQ_READ: begin
                    if (bus_ack) begin
                        data_q <= bus_rdata;
                        if (bus_err) begin
                            err_pend <= 1'b1;
                            state    <= SEQ_WRITE;
                        end else if (halt_all || !run_cur) begin
                            state <= SEQ_IDLE;
                        end else begin
                            state <= SEQ_WRITE;
                        end
                    end
                end
                SEQ_WRITE: begin
                    if (bus_ack) state <= SEQ_IDLE;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Bus outputs and completion strobes decoded from the state.
    always_comb begin
        bus_req   = (state != SEQ_IDLE);
        bus_wr    = (state == SEQ_WRITE);
        bus_addr  = (state == SEQ_WRITE) ? dst_cur : src_cur;
        bus_wdata = data_q;
        upd       = (state == SEQ_WRITE) && bus_ack;
        upd_fault = upd && (err_pend || bus_err);
    end
endmodule

// File: rtl/dma_term_ctrl.sv
// Top of the DMA termination controller: register decode, mode word,
// per-channel register banks, arbiter, sequencer and interrupt outputs.
// Assumes: NCH is a power of two >= 2; registers are word addressed.
module dma_term_ctrl
    import dma_term_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int AW    = 32,
    parameter int CNT_W = 16,
    parameter int STEP  = 4,
    parameter int RA_W  = $clog2(4 * NCH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [AW-1:0]   reg_wdata,
    output logic [AW-1:0]   reg_rdata,
    input  logic            nmi_evt,
    output logic            bus_req,
    output logic            bus_wr,
    output logic [AW-1:0]   bus_addr,
    output logic [AW-1:0]   bus_wdata,
    input  logic            bus_ack,
    input  logic [AW-1:0]   bus_rdata,
    input  logic            bus_err,
    output logic [NCH-1:0]  irq
);
    localparam int IW = $clog2(NCH);
    localparam logic [RA_W-1:0] MODE_ADDR = RA_W'(4 * NCH);

    logic [AW-1:0]    src_q [NCH];
    logic [AW-1:0]    dst_q [NCH];
    logic [CNT_W-1:0] cnt_q [NCH];
    logic [NCH-1:0]   run_v, ien_v, done_v, ready_v, upd_v;
    logic             mode_run, nmi_flag, fault_flag, halt_all;
    logic             mode_we, grant_any, upd, upd_fault;
    logic [IW-1:0]    grant_idx, cur_ch;

    // Halt condition shared by every channel.
    always_comb begin
        halt_all = !mode_run || nmi_flag || fault_flag;
        mode_we  = reg_we && (reg_addr == MODE_ADDR);
    end

    // Mode word: run bit written freely; flags set by events, cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_run   <= 1'b0;
            nmi_flag   <= 1'b0;
            fault_flag <= 1'b0;
        end else begin
            if (mode_we) begin
                mode_run <= reg_wdata[MODE_RUN];
                if (!reg_wdata[MODE_NMI])   nmi_flag   <= 1'b0;
                if (!reg_wdata[MODE_FAULT]) fault_flag <= 1'b0;
            end
            if (nmi_evt)   nmi_flag   <= 1'b1;
            if (upd_fault) fault_flag <= 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chan
            logic sel;
            // Channel decode and update steering for channel g.
            always_comb begin
                sel      = reg_we && (reg_addr < MODE_ADDR)
                           && (reg_addr[RA_W-1:2] == (RA_W - 2)'(g));
                upd_v[g] = upd && (cur_ch == IW'(g));
                irq[g]   = done_v[g] && ien_v[g];
            end

            dma_chan_regs #(
                .AW(AW), .CNT_W(CNT_W), .STEP(STEP)
            ) i_regs (
                .clk     (clk),
                .rst_n   (rst_n),
                .sw_we   (sel),
                .sw_fld  (reg_addr[1:0]),
                .sw_data (reg_wdata),
                .hw_upd  (upd_v[g]),
                .src_q   (src_q[g]),
                .dst_q   (dst_q[g]),
                .cnt_q   (cnt_q[g]),
                .run_q   (run_v[g]),
                .ien_q   (ien_v[g]),
                .done_q  (done_v[g]),
                .ready   (ready_v[g])
            );
        end
    endgenerate

    dma_prio_arb #(.NCH(NCH), .IW(IW)) i_arb (
        .req (ready_v & {NCH{!halt_all}}),
        .any (grant_any),
        .idx (grant_idx)
    );

    dma_xfer_seq #(.AW(AW), .IW(IW)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (grant_any),
        .start_ch  (grant_idx),
        .src_cur   (src_q[cur_ch]),
        .dst_cur   (dst_q[cur_ch]),
        .run_cur   (run_v[cur_ch]),
        .halt_all  (halt_all),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .bus_req   (bus_req),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cur_ch    (cur_ch),
        .upd       (upd),
        .upd_fault (upd_fault)
    );

    // Register read-back multiplexer; unmapped addresses read 0.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == MODE_ADDR) begin
            reg_rdata[MODE_RUN]   = mode_run;
            reg_rdata[MODE_NMI]   = nmi_flag;
            reg_rdata[MODE_FAULT] = fault_flag;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (reg_addr < MODE_ADDR && reg_addr[RA_W-1:2] == (RA_W - 2)'(i)) begin
                    case (reg_addr[1:0])
                        FLD_SRC: reg_rdata = src_q[i];
                        FLD_DST: reg_rdata = dst_q[i];
                        FLD_CNT: reg_rdata = AW'(cnt_q[i]);
                        default: begin
                            reg_rdata[CTL_RUN]  = run_v[i];
                            reg_rdata[CTL_IEN]  = ien_v[i];
                            reg_rdata[CTL_DONE] = done_v[i];
                        end
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/dma_term_chk.sv
// Protocol and stop-rule checker, bound into dma_term_ctrl.
// Assumes: the software does not rewrite the granted channel's pointers
// while a bus cycle of that channel waits for its acknowledge.
module dma_term_chk #(
    parameter int NCH = 4,
    parameter int AW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_req,
    input logic           bus_wr,
    input logic           bus_ack,
    input logic           bus_err,
    input logic [AW-1:0]  bus_addr,
    input logic           halt_all,
    input logic [NCH-1:0] done_v,
    input logic [NCH-1:0] ien_v,
    input logic [NCH-1:0] irq
);
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wr));

    p_write_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr) |-> $past(bus_req && !bus_wr && bus_ack));

    p_fault_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_wr && bus_ack && bus_err |=> bus_req && bus_wr);

    p_no_start_halted_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req && halt_all |=> !bus_req);

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            p_done_on_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(done_v[g]) |-> $past(bus_req && bus_wr && bus_ack));

            p_irq_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(irq[g]) |-> done_v[g] && ien_v[g]);
        end
    endgenerate
endmodule

bind dma_term_ctrl dma_term_chk #(.NCH(NCH), .AW(AW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_wr   (bus_wr),
    .bus_ack  (bus_ack),
    .bus_err  (bus_err),
    .bus_addr (bus_addr),
    .halt_all (halt_all),
    .done_v   (done_v),
    .ien_v    (ien_v),
    .irq      (irq)
);

// File: tb/test_dma_term_ctrl.sv
`timescale 1ns/1ps
module test_dma_term_ctrl;
    localparam int NCH = 4;
    localparam int AW  = 32;
    localparam int RA_W = 5;
    localparam logic [31:0] MASK = 32'hA5A5_0000;
    localparam logic [4:0]  MODE = 5'd16;

    typedef struct packed {
        logic [1:0]  ch;
        logic [31:0] src;
        logic [31:0] dst;
        logic [15:0] cnt;
        logic        ie;
        logic [31:0] esrc;
        logic [31:0] edst;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{2'd0, 32'h1000, 32'h2000, 16'd3, 1'b1, 32'h100C, 32'h200C},
        '{2'd1, 32'h1100, 32'h2100, 16'd1, 1'b0, 32'h1104, 32'h2104},
        '{2'd2, 32'h1200, 32'h2200, 16'd5, 1'b1, 32'h1214, 32'h2214},
        '{2'd3, 32'h1300, 32'h2300, 16'd2, 1'b0, 32'h1308, 32'h2308}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_we = 1'b0;
    logic [RA_W-1:0] reg_addr = '0;
    logic [AW-1:0]   reg_wdata = '0;
    logic [AW-1:0]   reg_rdata;
    logic            nmi_evt = 1'b0;
    logic            bus_req, bus_wr;
    logic [AW-1:0]   bus_addr, bus_wdata;
    logic            bus_ack = 1'b0;
    logic [AW-1:0]   bus_rdata = '0;
    logic            bus_err = 1'b0;
    logic [NCH-1:0]  irq;

    int n_chk = 0;
    int n_err = 0;
    int nwr = 0;
    int rd_n = 0;
    logic [31:0] rd_log [64];
    logic [31:0] last_wa, last_wd;

    always #2.5 clk = ~clk;

    dma_term_ctrl #(.NCH(NCH), .AW(AW)) i_dma_term_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_evt(nmi_evt),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .irq(irq)
    );

    // Bus slave: acknowledges each cycle one half-clock after request; region E faults.
    always @(negedge clk) begin
        if (bus_req && !bus_ack) begin
            bus_ack   <= 1'b1;
            bus_rdata <= bus_addr ^ MASK;
            bus_err   <= (bus_addr[31:28] == 4'hE);
            if (bus_wr) begin
                nwr     <= nwr + 1;
                last_wa <= bus_addr;
                last_wd <= bus_wdata;
            end else begin
                rd_log[rd_n % 64] <= bus_addr;
                rd_n <= rd_n + 1;
            end
        end else begin
            bus_ack <= 1'b0;
            bus_err <= 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_quiet();
        int q = 0;
        while (q < 8) begin
            @(negedge clk);
            if (bus_req) q = 0; else q++;
        end
    endtask

    task automatic setup(input int c, input logic [31:0] s, input logic [31:0] d, input logic [31:0] n);
        wr(5'(4*c), s);
        wr(5'(4*c+1), d);
        wr(5'(4*c+2), n);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        int nw0, d, rb;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state of the control words, mode word, bus and interrupts.
        for (int c = 0; c < NCH; c++) begin
            rd(5'(4*c+3), v); chk("R11 reset ctl", v, 32'h0);
        end
        rd(MODE, v); chk("R11 reset mode", v, 32'h0);
        chk("R11 reset bus_req/irq", {27'b0, bus_req, irq}, 32'h0);

        // R11: writing 1 to the flag bits has no effect.
        wr(MODE, 32'h7);
        rd(MODE, v); chk("R11 flag write-1 ignored", v, 32'h1);

        // Vector table: complete runs (R1, R2, R8, R10).
        for (int k = 0; k < 4; k++) begin
            int c = int'(VECS[k].ch);
            setup(c, VECS[k].src, VECS[k].dst, 32'(VECS[k].cnt));
            nw0 = nwr;
            wr(5'(4*c+3), {29'b0, 1'b0, VECS[k].ie, 1'b1});
            wait_quiet();
            rd(5'(4*c), v);   chk("R8 final src", v, VECS[k].esrc);
            rd(5'(4*c+1), v); chk("R8 final dst", v, VECS[k].edst);
            rd(5'(4*c+2), v); chk("R1 count zero", v, 32'h0);
            rd(5'(4*c+3), v); chk("R1 done set", v, {29'b0, 1'b1, VECS[k].ie, 1'b1});
            chk("R1 write count", 32'(nwr - nw0), 32'(VECS[k].cnt));
            chk("R10 last write addr", last_wa, VECS[k].edst - 32'd4);
            chk("R10 last write data", last_wd, (VECS[k].esrc - 32'd4) ^ MASK);
            chk("R2 irq follows ien", 32'(irq[c]), 32'(VECS[k].ie));
            wr(5'(4*c+3), {30'b0, VECS[k].ie, 1'b0});
            rd(5'(4*c+3), v); chk("R2 done cleared", v, {30'b0, VECS[k].ie, 1'b0});
            chk("R2 irq cleared", 32'(irq[c]), 32'h0);
        end

        // R9: fixed priority, one pair per grant.
        wr(MODE, 32'h0);
        setup(0, 32'h4000, 32'h5000, 2);
        setup(2, 32'h4200, 32'h5200, 2);
        wr(5'd11, 32'h1);
        wr(5'd3, 32'h1);
        rb = rd_n;
        wr(MODE, 32'h1);
        wait_quiet();
        chk("R9 grant 1", rd_log[rb % 64], 32'h4000);
        chk("R9 grant 2", rd_log[(rb+1) % 64], 32'h4004);
        chk("R9 grant 3", rd_log[(rb+2) % 64], 32'h4200);
        chk("R9 grant 4", rd_log[(rb+3) % 64], 32'h4204);
        wr(5'd3, 32'h0);
        wr(5'd11, 32'h0);

        // R3: clearing the run bit aborts silently.
        setup(0, 32'hA000, 32'hB000, 100);
        nw0 = nwr;
        wr(5'd3, 32'h3);
        repeat (15) @(negedge clk);
        wr(5'd3, 32'h2);
        wait_quiet();
        d = nwr - nw0;
        rd(5'd3, v); chk("R3 no done", v, 32'h2);
        rd(5'd2, v); chk("R3 count kept", v, 32'(100 - d));
        rd(5'd0, v); chk("R3 src kept", v, 32'hA000 + 32'(4*d));
        chk("R3 irq low", 32'(irq[0]), 32'h0);
        nw0 = nwr;
        repeat (20) @(negedge clk);
        chk("R3 stays idle", 32'(nwr - nw0), 32'h0);

        // R4/R5: NMI halt and the flag-clear then run-bit restart.
        setup(1, 32'h6000, 32'h7000, 100);
        nw0 = nwr;
        wr(5'd7, 32'h3);
        repeat (15) @(negedge clk);
        nmi_evt = 1'b1;
        @(negedge clk);
        nmi_evt = 1'b0;
        wait_quiet();
        d = nwr - nw0;
        rd(MODE, v); chk("R4 nmi flag", v, 32'h3);
        rd(5'd7, v); chk("R4 no done", v, 32'h3);
        rd(5'd6, v); chk("R4 count kept", v, 32'(100 - d));
        rd(5'd5, v); chk("R4 dst kept", v, 32'h7000 + 32'(4*d));
        chk("R4 irq low", 32'(irq[1]), 32'h0);
        nw0 = nwr;
        repeat (20) @(negedge clk);
        chk("R5 halted while flag set", 32'(nwr - nw0), 32'h0);
        wr(5'd7, 32'h2);
        wr(MODE, 32'h1);
        repeat (20) @(negedge clk);
        chk("R5 no restart with run clear", 32'(nwr - nw0), 32'h0);
        wr(5'd7, 32'h3);
        wait_quiet();
        rd(5'd6, v); chk("R5 resumed to zero", v, 32'h0);
        rd(5'd7, v); chk("R5 done after resume", v, 32'h7);
        chk("R2 irq after resume", 32'(irq[1]), 32'h1);
        wr(5'd7, 32'h0);

        // R6: read fault still writes, updates, sets fault flag, halts.
        setup(2, 32'hE000_0000, 32'h3000, 3);
        nw0 = nwr;
        wr(5'd11, 32'h1);
        wait_quiet();
        chk("R6 one write", 32'(nwr - nw0), 32'h1);
        chk("R6 write addr", last_wa, 32'h3000);
        chk("R6 write data", last_wd, 32'hE000_0000 ^ MASK);
        rd(5'd8, v);  chk("R6 src advanced", v, 32'hE000_0004);
        rd(5'd10, v); chk("R6 count", v, 32'h2);
        rd(5'd11, v); chk("R6 no done", v, 32'h1);
        rd(MODE, v);  chk("R6 fault flag", v, 32'h5);
        wr(5'd11, 32'h0);
        wr(MODE, 32'h1);

        // R7: global run bit cleared stops everything.
        setup(3, 32'h8000, 32'h9000, 100);
        nw0 = nwr;
        wr(5'd15, 32'h1);
        repeat (15) @(negedge clk);
        wr(MODE, 32'h0);
        wait_quiet();
        d = nwr - nw0;
        rd(5'd15, v); chk("R7 no done", v, 32'h1);
        rd(5'd14, v); chk("R7 count kept", v, 32'(100 - d));
        rd(5'd13, v); chk("R7 dst kept", v, 32'h9000 + 32'(4*d));
        nw0 = nwr;
        repeat (20) @(negedge clk);
        chk("R7 stays idle", 32'(nwr - nw0), 32'h0);

        summary();
        $finish;
    end
endmodule